// File: doc/BRIEF.md
# Translation Storage Buffer Pointer Generator

This block keeps the configuration that a memory management unit needs to locate the translation-storage-buffer entry for the most recent faulting virtual address. Software, or the fault path, writes the tag-access value (virtual page bits above a 13-bit context field), four buffer base/configuration words and two context configuration words through a single register write port. A read port then returns the entry pointer for one of two page-size indices, one clock after the request.

A mode input picks between two behaviours. In legacy mode the page size is fixed by the request index (index 0 means 8 KB, index 1 means 64 KB) and only buffer slot 0 is used. In hypervisor mode the buffer slot and the page-size code both come from the request index and from whether the context in the tag-access word is zero. The pointer is built by merging the buffer base with virtual-address bits shifted down by the page size. The merge boundary moves up with the size field of the chosen buffer word. A split flag in that word divides the buffer into two halves, one for each index.

Top module: `tsb_ptr_gen`

## Requirements
- R1: After reset all stored words are zero, `rd_valid_o` is low, `rd_ptr_o` is zero, and a read before any write returns zero.
- R2: `rd_valid_o` is high for exactly the cycle after each clock edge at which `rd_req_i` is high, and low after every edge at which it is low.
- R3: The context is the tag-access field [12:0]. It counts as nonzero when any one of those 13 bits is set, including only bit 12 or only bit 0.
- R4: In hypervisor mode (`mode_hv_i`=1) the buffer slot is 2*ctx_nonzero + index.
- R5: In hypervisor mode the 3-bit page-size code comes from the zero-context configuration word when the context is zero and from the nonzero-context word otherwise. The code is field [2:0] for index 0 and field [10:8] for index 1. Other bits of those words have no effect.
- R6: In legacy mode (`mode_hv_i`=0) the page-size code equals the index and slot 0 is always used, whatever the context.
- R7: With S = chosen word bits [3:0] and P = page-size code, the mask is all ones from bit 13 upward shifted left by S, and VA = tag-access >> (3*P + 9). The pointer is (word AND mask) OR (VA AND NOT mask).
- R8: When bit 12 of the chosen word is set, the mask is shifted left by one more place. VA bit 13+S is cleared for index 0 and set for index 1 before the merge.
- R9: Bits [3:0] of every returned pointer are zero.
- R10: A write with `wr_en_i`=1 stores `wr_data_i` into the word picked by `wr_sel_i`: 0 tag-access, 1 to 4 buffer slots 0 to 3, 5 zero-context configuration, 6 nonzero-context configuration. Select value 7 changes nothing.
- R11: `rd_ptr_o` holds its value between requests. A request made at the same edge as a write uses the stored words from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_hv_i | input | 1 | 1 selects hypervisor mode, 0 selects legacy mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 64 | Write data |
| rd_req_i | input | 1 | Pointer request |
| rd_idx_i | input | 1 | Page-size index of the request |
| rd_valid_o | output | 1 | Pointer valid, one cycle after the request |
| rd_ptr_o | output | 64 | Computed buffer entry pointer |

## Verification
Every stored word reaches the ports only through the next pointer read, so a bad register or a wrong select decode shows up as a wrong pointer one cycle after the first request that depends on it. To catch that at once, each sweep step fills all four buffer slots with different upper bits and both configuration words with different codes and noise bits. A wrong slot, the wrong configuration word or the wrong field then changes the very next pointer. Sweeping the size field, the split flag, the index, the mode and zero and nonzero contexts exercises every mask boundary and every split bit position. A fault that appears only for some shift amounts cannot hide across the sweep.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned PS_W      = 3;
  localparam int unsigned SIZE_W    = 4;
  localparam int unsigned SPLIT_BIT = 12;

  typedef enum logic [SEL_W-1:0] {
    SEL_TAG   = 3'd0,
    SEL_SLOT0 = 3'd1,
    SEL_SLOT1 = 3'd2,
    SEL_SLOT2 = 3'd3,
    SEL_SLOT3 = 3'd4,
    SEL_CFGZ  = 3'd5,
    SEL_CFGN  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [PS_W-1:0] ps_hi;
    logic [PS_W-1:0] ps_lo;
  } ctx_cfg_t;
endpackage

// File: rtl/tsbp_regfile.sv
module tsbp_regfile
  import tsbp_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HI_LSB  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SEL_W-1:0]                  wr_sel_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [DATA_W-1:0]                 tag_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_o,
  output ctx_cfg_t                          cfg_z_o,
  output ctx_cfg_t                          cfg_n_o
);
  logic [DATA_W-1:0] tag_q;
  ctx_cfg_t          cfg_z_q, cfg_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
    end else if (wr_en_i && wr_sel_i == SEL_TAG) begin
      tag_q <= wr_data_i;
    end
  end

  // only the page-size fields are kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_z_q <= '0;
      cfg_n_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CFGZ) begin
        cfg_z_q.ps_lo <= wr_data_i[PS_W-1:0];
        cfg_z_q.ps_hi <= wr_data_i[HI_LSB+PS_W-1:HI_LSB];
      end
      if (wr_sel_i == SEL_CFGN) begin
        cfg_n_q.ps_lo <= wr_data_i[PS_W-1:0];
        cfg_n_q.ps_hi <= wr_data_i[HI_LSB+PS_W-1:HI_LSB];
      end
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(k + 1);
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (wr_en_i && wr_sel_i == MY_SEL) begin
        slot_q <= wr_data_i;
      end
    end
    assign slot_o[k] = slot_q;
  end

  assign tag_o   = tag_q;
  assign cfg_z_o = cfg_z_q;
  assign cfg_n_o = cfg_n_q;
endmodule

// File: rtl/tsbp_select.sv
module tsbp_select
  import tsbp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CTX_W  = 13
) (
  input  logic                              mode_hv_i,
  input  logic                              idx_i,
  input  logic [DATA_W-1:0]                 tag_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_i,
  input  ctx_cfg_t                          cfg_z_i,
  input  ctx_cfg_t                          cfg_n_i,
  output logic [DATA_W-1:0]                 word_o,
  output logic [PS_W-1:0]                   ps_o
);
  logic     ctx_nz;
  logic [1:0] slot_idx;
  ctx_cfg_t cfg;

  assign ctx_nz = |tag_i[CTX_W-1:0];
  assign cfg    = ctx_nz ? cfg_n_i : cfg_z_i;

  always_comb begin
    if (mode_hv_i) begin
      slot_idx = {ctx_nz, idx_i};
      ps_o     = idx_i ? cfg.ps_hi : cfg.ps_lo;
    end else begin
      slot_idx = 2'd0;
      ps_o     = {{(PS_W-1){1'b0}}, idx_i};
    end
  end

  assign word_o = slot_i[slot_idx];
endmodule

// File: rtl/tsbp_merge.sv
module tsbp_merge
  import tsbp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CTX_W  = 13,
  parameter int unsigned ALIGN  = 4
) (
  input  logic              idx_i,
  input  logic [DATA_W-1:0] tag_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [PS_W-1:0]   ps_i,
  output logic [DATA_W-1:0] ptr_o
);
  localparam int unsigned SH_W = 6;
  localparam logic [DATA_W-1:0] BASE_MASK = {DATA_W{1'b1}} << CTX_W;
  localparam logic [DATA_W-1:0] ALIGN_MASK = {DATA_W{1'b1}} << ALIGN;

  logic [SIZE_W-1:0] size;
  logic              split;
  logic [SH_W-1:0]   va_sh;
  logic [SH_W-1:0]   half_pos;
  logic [DATA_W-1:0] half_bit;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] va;

  assign size     = word_i[SIZE_W-1:0];
  assign split    = word_i[SPLIT_BIT];
  assign va_sh    = SH_W'(9) + SH_W'(ps_i) * SH_W'(3);
  assign half_pos = SH_W'(CTX_W) + SH_W'(size);
  assign half_bit = DATA_W'(1) << half_pos;

  always_comb begin
    mask = BASE_MASK << size;
    va   = tag_i >> va_sh;
    if (split) begin
      mask = mask << 1;
      va   = idx_i ? (va | half_bit) : (va & ~half_bit);
    end
    ptr_o = ((word_i & mask) | (va & ~mask)) & ALIGN_MASK;
  end
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsbp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CTX_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_hv_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic              rd_idx_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_ptr_o
);
  logic [DATA_W-1:0]                tag;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot;
  ctx_cfg_t                         cfg_z, cfg_n;
  logic [DATA_W-1:0]                word;
  logic [PS_W-1:0]                  ps;
  logic [DATA_W-1:0]                ptr_d, ptr_q;
  logic                             valid_q;

  tsbp_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .tag_o(tag), .slot_o(slot), .cfg_z_o(cfg_z), .cfg_n_o(cfg_n)
  );

  tsbp_select #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_sel (
    .mode_hv_i, .idx_i(rd_idx_i), .tag_i(tag), .slot_i(slot),
    .cfg_z_i(cfg_z), .cfg_n_i(cfg_n), .word_o(word), .ps_o(ps)
  );

  tsbp_merge #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_merge (
    .idx_i(rd_idx_i), .tag_i(tag), .word_i(word), .ps_i(ps), .ptr_o(ptr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      valid_q <= rd_req_i;
      if (rd_req_i) ptr_q <= ptr_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_ptr_o   = ptr_q;
endmodule

// File: rtl/tsb_ptr_gen_chk.sv
module tsb_ptr_gen_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_ptr_o
);
  // R2
  valid_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  // R2
  no_valid_without_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);
  // R9
  ptr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_ptr_o[3:0] == 4'h0);
  // R11
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_ptr_o));
endmodule

bind tsb_ptr_gen tsb_ptr_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_req_i(rd_req_i),
  .rd_valid_o(rd_valid_o), .rd_ptr_o(rd_ptr_o)
);

// File: tb/test_tsb_ptr_gen.sv
`timescale 1ns/1ps
module test_tsb_ptr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_hv = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [63:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic        rd_idx = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_ptr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_tag;
  logic [63:0] m_slot [4];
  logic [63:0] m_cfgz, m_cfgn;

  always #4 clk = ~clk;

  tsb_ptr_gen i_tsb_ptr_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_hv_i(mode_hv),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_ptr_o(rd_ptr)
  );

  function automatic logic [63:0] model(bit hv, bit idx);
    bit nz;
    logic [63:0] w, m, v, cfg;
    int ps, sz;
    nz = |m_tag[12:0];
    if (hv) begin
      w   = m_slot[{nz, idx}];
      cfg = nz ? m_cfgn : m_cfgz;
      ps  = idx ? int'(cfg[10:8]) : int'(cfg[2:0]);
    end else begin
      w  = m_slot[0];
      ps = idx;
    end
    sz = int'(w[3:0]);
    m  = (~64'h1fff) << sz;
    v  = m_tag >> (3 * ps + 9);
    if (w[12]) begin
      if (idx) v = v | (64'd1 << (13 + sz));
      else     v = v & ~(64'd1 << (13 + sz));
      m = m << 1;
    end
    return ((w & m) | (v & ~m)) & ~64'hf;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [2:0] sel, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: m_tag = d;
      3'd1, 3'd2, 3'd3, 3'd4: m_slot[sel - 3'd1] = d;
      3'd5: m_cfgz = d;
      3'd6: m_cfgn = d;
      default: ;
    endcase
  endtask

  task automatic read_chk(bit idx, string req);
    logic [63:0] exp;
    logic [63:0] held;
    exp = model(mode_hv, idx);
    @(negedge clk);
    rd_req = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_req = 1'b0;
    check("R2 valid", {63'd0, rd_valid}, 64'd1);
    check(req, rd_ptr, exp);
    check("R9 align", {60'd0, rd_ptr[3:0]}, 64'd0);
    held = rd_ptr;
    @(negedge clk);
    check("R2 drop", {63'd0, rd_valid}, 64'd0);
    check("R11 hold", rd_ptr, held);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_tag = '0; m_cfgz = '0; m_cfgn = '0;
    for (int k = 0; k < 4; k++) m_slot[k] = '0;
    #20;
    check("R1 valid", {63'd0, rd_valid}, 64'd0);
    check("R1 ptr", rd_ptr, 64'd0);
    rst_n = 1'b1;
    read_chk(1'b0, "R1 zero read");
    mode_hv = 1'b1;
    read_chk(1'b1, "R1 zero read hv");

    // main sweep: R4 R5 R6 R7 R8
    for (int hv = 0; hv < 2; hv++) begin
      for (int nz = 0; nz < 2; nz++) begin
        for (int sz = 0; sz < 16; sz++) begin
          for (int sp = 0; sp < 2; sp++) begin
            logic [63:0] base;
            logic [12:0] ctx;
            mode_hv = hv[0];
            ctx = nz ? 13'((sz * 517 + sp * 91) % 8191 + 1) : 13'd0;
            write_reg(3'd0, (64'hC3A5_96F0_7E1D_2B48 ^ (64'(sz) << 40) ^ (64'(sp) << 23))
                            & ~64'h1fff | 64'(ctx));
            for (int k = 0; k < 4; k++) begin
              base = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 3 + sz);
              base = base & ~64'h1fff;
              write_reg(3'(k + 1), base | (64'(sp) << 12) | 64'(sz));
            end
            write_reg(3'd5, 64'hFFFF_0000_F0F0_F8F8 & ~64'h707 |
                            (64'((sz + sp) % 8) << 8) | 64'((sz * 3 + 1) % 8));
            write_reg(3'd6, 64'h0F0F_1234_8888_F0F8 & ~64'h707 |
                            (64'((sz * 5 + 2 + sp) % 8) << 8) | 64'((7 - sz + sp) % 8));
            for (int ix = 0; ix < 2; ix++) begin
              if (hv == 0)      read_chk(ix[0], "R6 legacy");
              else if (sp != 0) read_chk(ix[0], "R8 split hv");
              else              read_chk(ix[0], "R4/R5/R7 hv");
            end
          end
        end
      end
    end

    // R3: single context bits
    mode_hv = 1'b1;
    write_reg(3'd0, 64'h1234_5678_9ABC_E000 | 64'h1000);
    read_chk(1'b1, "R3 ctx bit12");
    write_reg(3'd0, 64'h1234_5678_9ABC_E000 | 64'h0001);
    read_chk(1'b0, "R3 ctx bit0");
    write_reg(3'd0, 64'h1234_5678_9ABC_E000);
    read_chk(1'b1, "R3 ctx zero");

    // R10: select 7 ignored
    write_reg(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    read_chk(1'b0, "R10 sel7 idx0");
    read_chk(1'b1, "R10 sel7 idx1");

    // R11: request with write at same edge uses old values
    begin
      logic [63:0] exp_old, exp_new;
      mode_hv = 1'b0;
      exp_old = model(1'b0, 1'b1);
      @(negedge clk);
      rd_req = 1'b1; rd_idx = 1'b1;
      wr_en = 1'b1; wr_sel = 3'd1; wr_data = 64'hABCD_EF01_2345_0003;
      @(negedge clk);
      rd_req = 1'b0; wr_en = 1'b0;
      m_slot[0] = 64'hABCD_EF01_2345_0003;
      check("R11 same-edge old", rd_ptr, exp_old);
      exp_new = model(1'b0, 1'b1);
      read_chk(1'b1, "R10 new slot0");
      check("R11 new differs", {63'd0, exp_new != exp_old}, 64'd1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule